// File: doc/BRIEF.md
# Playback Byte Counter and Block Interrupt

This block sits between a DMA channel and an audio output path and keeps count of the playback bytes that have crossed over. Software programs a 16-bit block count and a frame-size shift (log2 of bytes per frame). The block scales the count into a terminal byte count. When the running count reaches it, the block issues a one-cycle set pulse for the status interrupt flag and another for the playback interrupt flag, and the count starts again from zero.

The block also owns the DMA request line. Turning playback on from idle raises the request and clears the count. Turning it off drops the request. A format-decode error holds the request low for as long as it lasts. For each burst the block presents a byte limit to the DMA engine. While block interrupts are enabled, the limit is the smaller of the bytes left to the terminal count and the free space in the output buffer. Otherwise it is the free space alone. Register storage and sample conversion live elsewhere.

Top module: `pbk_xfer_ctr`

## Requirements
- R1: After reset `dma_req_o`, `int_set_o` and `pi_set_o` are 0 and the transferred count is 0, so `burst_lim_o` equals `min(term, out_free_i)` when `irq_en_i` is 1.
- R2: The terminal count is `base_cnt_i` shifted left by `frame_shift_i`. A byte is accepted on each clock edge where `byte_ack_i` and `dma_req_o` are both 1. When the accepted byte brings the count to the terminal count, `int_set_o` and `pi_set_o` are both 1 for the following cycle and the count returns to 0.
- R3: While `irq_en_i` is 0, accepted bytes never produce `int_set_o` or `pi_set_o`.
- R4: With `irq_en_i` at 1, `burst_lim_o` is the smaller of (terminal minus count, or 0 if the count has reached or passed it) and `out_free_i`. With `irq_en_i` at 0, `burst_lim_o` equals `out_free_i`.
- R5: Raising `play_en_i` while idle makes `dma_req_o` 1 from the next cycle and clears the count.
- R6: With `play_en_i` at 0, `dma_req_o` is 0 from the next cycle.
- R7: While `fmt_err_i` is 1, `dma_req_o` is 0 in the same cycle. The count is kept, and when the error clears the request returns without the count being cleared.
- R8: `byte_ack_i` pulses while `dma_req_o` is 0 leave the count unchanged.
- R9: The count is wide enough for a base count of 0xFFFF at the largest shift (2), so the terminal value is 0x3FFFC with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_cnt_i | input | 16 | Programmed block count |
| frame_shift_i | input | 2 | log2 of bytes per frame, 0..2 |
| irq_en_i | input | 1 | Enables block counting and interrupts |
| play_en_i | input | 1 | Playback enable |
| fmt_err_i | input | 1 | Format decode error, level |
| byte_ack_i | input | 1 | One byte taken by the output |
| out_free_i | input | 18 | Free bytes in the output buffer |
| dma_req_o | output | 1 | DMA request |
| int_set_o | output | 1 | Set pulse for the status interrupt flag |
| pi_set_o | output | 1 | Set pulse for the playback interrupt flag |
| burst_lim_o | output | 18 | Byte limit for the current burst |

## Verification
The transferred count is internal. It can only be seen through `burst_lim_o`, and only while interrupts are enabled and the free space is larger than the remaining bytes. The bench therefore keeps `out_free_i` at its maximum whenever it needs to read the count back. It reads that limit before and after each event that should leave the count alone: an error window, byte acknowledges with the request low, and an error that clears while playback stays on. The hardest case to reach is the full-range terminal of 0x3FFFC. It is checked through the limit value rather than by moving a quarter of a million bytes.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;
endpackage

// File: rtl/pbk_term_calc.sv
module pbk_term_calc #(
   parameter int BASE_W    = 16,
   parameter int MAX_SHIFT = 2,
   localparam int CNT_W    = BASE_W + MAX_SHIFT,
   localparam int SH_W     = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [SH_W-1:0]   shift_i,
   output logic [CNT_W-1:0]  term_o
);
   logic [CNT_W-1:0] cand [MAX_SHIFT+1];

   // one pre-shifted candidate for each legal shift
   for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_cand
      assign cand[s] = CNT_W'(base_i) << s;
   end

   always_comb begin
      term_o = cand[MAX_SHIFT];
      for (int i = 0; i <= MAX_SHIFT; i++) begin
         if (shift_i == SH_W'(i)) term_o = cand[i];
      end
   end

   initial begin
      if (BASE_W < 1) $error("BASE_W must be positive");
      if (MAX_SHIFT < 0) $error("MAX_SHIFT must not be negative");
   end
endmodule

// File: rtl/pbk_req_ctl.sv
module pbk_req_ctl
   import pbk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic play_en_i,
   input  logic fmt_err_i,
   output logic start_o,
   output logic dma_req_o
);
   run_st_e state_q;

   assign start_o   = play_en_i && (state_q == ST_IDLE);
   assign dma_req_o = (state_q == ST_RUN) && !fmt_err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          state_q <= ST_IDLE;
      else if (!play_en_i) state_q <= ST_IDLE;
      else                 state_q <= ST_RUN;
   end

   // R6
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !play_en_i |=> !dma_req_o);
   // R5
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && play_en_i) |=> (dma_req_o || fmt_err_i));
endmodule

// File: rtl/pbk_byte_ctr.sv
module pbk_byte_ctr #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             acc_i,
   input  logic             irq_en_i,
   input  logic [CNT_W-1:0] term_i,
   output logic [CNT_W-1:0] xfer_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] xfer_q;
   logic [CNT_W-1:0] xfer_inc;
   logic             hit;
   logic             irq_q;

   assign xfer_inc = xfer_q + CNT_W'(1);
   assign hit      = acc_i && irq_en_i && (xfer_inc == term_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= hit;
         if (start_i || hit) xfer_q <= '0;
         else if (acc_i)     xfer_q <= xfer_inc;
      end
   end

   assign xfer_o = xfer_q;
   assign irq_o  = irq_q;

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (xfer_q == '0));
   // R3
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(irq_en_i));
   // R5
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (xfer_q == '0));

   initial begin
      if (CNT_W < 2) $error("CNT_W too small");
   end
endmodule

// File: rtl/pbk_burst_lim.sv
module pbk_burst_lim #(
   parameter int CNT_W = 18
) (
   input  logic             irq_en_i,
   input  logic [CNT_W-1:0] term_i,
   input  logic [CNT_W-1:0] xfer_i,
   input  logic [CNT_W-1:0] free_i,
   output logic [CNT_W-1:0] lim_o
);
   logic [CNT_W-1:0] remain;

   assign remain = (term_i > xfer_i) ? (term_i - xfer_i) : '0;

   always_comb begin
      if (!irq_en_i)           lim_o = free_i;
      else if (remain < free_i) lim_o = remain;
      else                     lim_o = free_i;
   end
endmodule

// File: rtl/pbk_xfer_ctr.sv
module pbk_xfer_ctr #(
   parameter int BASE_W    = 16,
   parameter int MAX_SHIFT = 2,
   localparam int CNT_W    = BASE_W + MAX_SHIFT,
   localparam int SH_W     = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] base_cnt_i,
   input  logic [SH_W-1:0]   frame_shift_i,
   input  logic              irq_en_i,
   input  logic              play_en_i,
   input  logic              fmt_err_i,
   input  logic              byte_ack_i,
   input  logic [CNT_W-1:0]  out_free_i,
   output logic              dma_req_o,
   output logic              int_set_o,
   output logic              pi_set_o,
   output logic [CNT_W-1:0]  burst_lim_o
);
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] xfer;
   logic             start;
   logic             req;
   logic             irq;

   pbk_term_calc #(.BASE_W(BASE_W), .MAX_SHIFT(MAX_SHIFT)) i_term (
      .base_i (base_cnt_i),
      .shift_i(frame_shift_i),
      .term_o (term)
   );

   pbk_req_ctl i_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .play_en_i(play_en_i),
      .fmt_err_i(fmt_err_i),
      .start_o  (start),
      .dma_req_o(req)
   );

   pbk_byte_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .acc_i   (byte_ack_i && req),
      .irq_en_i(irq_en_i),
      .term_i  (term),
      .xfer_o  (xfer),
      .irq_o   (irq)
   );

   pbk_burst_lim #(.CNT_W(CNT_W)) i_lim (
      .irq_en_i(irq_en_i),
      .term_i  (term),
      .xfer_i  (xfer),
      .free_i  (out_free_i),
      .lim_o   (burst_lim_o)
   );

   assign dma_req_o = req;
   assign int_set_o = irq;
   assign pi_set_o  = irq;

   // R8
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !start) |=> $stable(xfer));
   // R4
   lim_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_lim_o <= out_free_i);
   // R7
   err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_i |-> !dma_req_o);
endmodule

// File: tb/test_pbk_xfer_ctr.sv
module test_pbk_xfer_ctr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] base_cnt_i = '0;
   logic [1:0]  frame_shift_i = '0;
   logic        irq_en_i = 1'b0;
   logic        play_en_i = 1'b0;
   logic        fmt_err_i = 1'b0;
   logic        byte_ack_i = 1'b0;
   logic [17:0] out_free_i = 18'h3FFFF;
   logic        dma_req_o, int_set_o, pi_set_o;
   logic [17:0] burst_lim_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pbk_xfer_ctr i_pbk_xfer_ctr (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive n acknowledges, return the number of interrupt pulses seen
   task automatic acks(input int n, output int nint, output int npi);
      nint = 0; npi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk) byte_ack_i = 1'b1;
         @(negedge clk) byte_ack_i = 1'b0;
         nint += int'(int_set_o);
         npi  += int'(pi_set_o);
      end
   endtask

   task automatic t_reset();
      base_cnt_i = 16'd5; irq_en_i = 1'b1;
      @(negedge clk);
      chk("R1 req", dma_req_o, 0);
      chk("R1 int", int_set_o, 0);
      chk("R1 pi", pi_set_o, 0);
      chk("R1 lim", burst_lim_o, 5);
   endtask

   task automatic t_start();
      play_en_i = 1'b1;
      #1 chk("R5 req before edge", dma_req_o, 0);
      @(negedge clk);
      chk("R5 req", dma_req_o, 1);
   endtask

   task automatic t_block();
      int ni, np;
      base_cnt_i = 16'd3; frame_shift_i = 2'd0; irq_en_i = 1'b1;
      #1 chk("R4 lim full", burst_lim_o, 3);
      acks(2, ni, np);
      chk("R2 no early int", ni, 0);
      chk("R4 lim remain", burst_lim_o, 1);
      acks(1, ni, np);
      chk("R2 int at term", ni, 1);
      chk("R2 pi at term", np, 1);
      chk("R2 count wraps", burst_lim_o, 3);
      @(negedge clk);
      chk("R2 pulse one cycle", int_set_o, 0);
   endtask

   task automatic t_shift();
      int ni, np;
      base_cnt_i = 16'd2; frame_shift_i = 2'd2;
      #1 chk("R2 shifted term", burst_lim_o, 8);
      acks(7, ni, np);
      chk("R2 shift no early", ni, 0);
      acks(1, ni, np);
      chk("R2 shift int", ni, 1);
   endtask

   task automatic t_free();
      out_free_i = 18'd2;
      #1 chk("R4 free cap", burst_lim_o, 2);
      irq_en_i = 1'b0; out_free_i = 18'd77;
      #1 chk("R4 unlimited", burst_lim_o, 77);
      out_free_i = 18'h3FFFF;
   endtask

   task automatic t_noien();
      int ni, np;
      base_cnt_i = 16'd2; frame_shift_i = 2'd0; irq_en_i = 1'b0;
      acks(5, ni, np);
      chk("R3 no int", ni, 0);
      chk("R3 no pi", np, 0);
   endtask

   task automatic t_err();
      int ni, np;
      // restart to get a clean count
      play_en_i = 1'b0; @(negedge clk);
      chk("R6 req drop", dma_req_o, 0);
      base_cnt_i = 16'd10; irq_en_i = 1'b1;
      play_en_i = 1'b1; @(negedge clk);
      chk("R5 restart clears", burst_lim_o, 10);
      acks(3, ni, np);
      chk("R7 before err", burst_lim_o, 7);
      fmt_err_i = 1'b1;
      #1 chk("R7 req low", dma_req_o, 0);
      acks(4, ni, np);
      chk("R7 count held", burst_lim_o, 7);
      fmt_err_i = 1'b0;
      #1 chk("R7 req back", dma_req_o, 1);
      @(negedge clk);
      chk("R7 not cleared", burst_lim_o, 7);
   endtask

   task automatic t_idle_ack();
      int ni, np;
      play_en_i = 1'b0; @(negedge clk);
      acks(4, ni, np);
      chk("R8 no int", ni, 0);
      chk("R8 count held", burst_lim_o, 7);
   endtask

   task automatic t_big();
      base_cnt_i = 16'hFFFF; frame_shift_i = 2'd2; irq_en_i = 1'b1;
      play_en_i = 1'b1; @(negedge clk);
      chk("R9 full range", burst_lim_o, 18'h3FFFC);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_start();
      t_block();
      t_shift();
      t_free();
      t_noien();
      t_err();
      t_idle_ack();
      t_big();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule